// File: doc/BRIEF.md
# Rotating-Immediate Operand Shifter

This combinational unit forms the second ALU operand of a 32-bit data-processing instruction. It receives the raw instruction word together with the values already read for the Rm and Rs registers, and it returns the operand with the shifter carry that the flag logic uses when it updates the condition codes. Three operand forms are handled. The first is a 9-bit constant, zero-extended and rotated left by a 5-bit amount. The second is a register shifted by a constant amount. The third is a register shifted by an amount taken from a second register.

Alongside the operand, the unit flags instructions that are not data-processing operand forms. It reports the S (flag update) bit. It also recognises the two move opcodes whose otherwise unused first-source field carries a condition, which makes them conditional moves, and it forwards that condition field. The ALU, the register file and flag storage sit outside this block.

Top module: `rot_operand_shifter`

## Requirements
- R1: The operand is valid when bits 31:29 are 001, or when they are 000 and bit 8 is 0. In every other case operand_o is 0, carry_o equals carry_i, and cmov_o and flags_upd_o are 0.
- R2: When bits 31:29 are 001, operand_o is bits 8:0 zero-extended to 32 bits and rotated left by the amount in bits 13:9.
- R3: In the immediate form, carry_o equals bit 31 of operand_o when the rotation amount is non-zero, and equals carry_i when it is zero.
- R4: In a register form, bit 5 = 0 takes the shift amount from bits 13:9. Bit 5 = 1 takes it from bits 4:0 of rs_val_i, and bits 31:5 of rs_val_i have no effect.
- R5: In a register form, bits 7:6 select the shift applied to rm_val_i: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R6: For a non-zero register shift amount n, carry_o is the last bit moved out. That is rm_val_i[32-n] for a left shift and rm_val_i[n-1] for the three right shifts.
- R7: A register shift amount of zero passes rm_val_i unchanged to operand_o and carry_i to carry_o, whatever the shift type.
- R8: cmov_o is 1 exactly when the operand is valid and the opcode in bits 28:25 is 1101 (move) or 1111 (move inverted). cmov_cond_o always shows bits 23:19.
- R9: flags_upd_o equals bit 24 when the operand is valid, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rm_val_i | input | 32 | Value of register Rm |
| rs_val_i | input | 32 | Value of register Rs (register-specified shift amount) |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Second ALU operand |
| carry_o | output | 1 | Shifter carry-out |
| op_valid_o | output | 1 | Instruction uses a shifter operand form |
| flags_upd_o | output | 1 | Instruction updates condition codes |
| cmov_o | output | 1 | Instruction is a conditional move |
| cmov_cond_o | output | 5 | Condition field of a conditional move |

## Verification
The hardest cases to reach are the ones where the carry-out must come from the incoming flag rather than from the shifter. This happens when a register-specified amount is zero in its low five bits while its upper bits are not, and when the instruction is a near-miss of the operand encodings with bit 8 set under class 000. The stimulus table builds instructions field by field, so these cases are placed directly, such as an Rs value of 0x20 or a bit-8 pattern. Extreme amounts of 31 are also placed, where the carry index sits at the opposite end of the word.

// File: rtl/rot_pkg.sv
package rot_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  localparam logic [2:0] CLS_REG = 3'b000;
  localparam logic [2:0] CLS_IMM = 3'b001;
  localparam logic [3:0] OPC_MOVE     = 4'b1101;
  localparam logic [3:0] OPC_MOVE_INV = 4'b1111;

endpackage

// File: rtl/rot_decode.sv
module rot_decode
  import rot_pkg::*;
#(
  parameter int IMM_W = 9,
  parameter int AMT_W = 5,
  parameter int REG_W = 5
) (
  input  logic [31:0]      instr,
  output logic             is_imm,
  output logic             is_valid,
  output logic             amt_from_reg,
  output shift_kind_e      kind,
  output logic [AMT_W-1:0] amt_field,
  output logic [IMM_W-1:0] imm_field,
  output logic             flags_upd,
  output logic             is_cmov,
  output logic [REG_W-1:0] cond_field
);

  logic [2:0] cls;
  logic [3:0] opc;
  logic       is_reg;
  logic [4:0] unused_rd;

  assign cls       = instr[31:29];
  assign opc       = instr[28:25];
  assign unused_rd = instr[18:14];

  always_comb begin
    is_imm       = (cls == CLS_IMM);
    is_reg       = (cls == CLS_REG) && !instr[8];
    is_valid     = is_imm || is_reg;
    amt_from_reg = instr[5];
    kind         = shift_kind_e'(instr[7:6]);
    amt_field    = instr[9 +: AMT_W];
    imm_field    = instr[IMM_W-1:0];
    flags_upd    = is_valid && instr[24];
    is_cmov      = is_valid && ((opc == OPC_MOVE) || (opc == OPC_MOVE_INV));
    cond_field   = instr[19 +: REG_W];
  end

endmodule

// File: rtl/rot_imm_rotator.sv
module rot_imm_rotator #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 9,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [AMT_W-1:0]  amt,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output logic              carry_out
);

  localparam logic [AMT_W:0] FULL = (AMT_W+1)'(DATA_W);

  logic [DATA_W-1:0] ext;
  logic [AMT_W:0]    back;

  always_comb begin
    ext       = DATA_W'(imm);
    back      = FULL - {1'b0, amt};
    res       = (ext << amt) | (ext >> back);
    carry_out = (amt == '0) ? carry_in : res[DATA_W-1];
  end

endmodule

// File: rtl/rot_barrel.sv
module rot_barrel
  import rot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [AMT_W-1:0]  amt,
  input  shift_kind_e       kind,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output logic              carry_out
);

  localparam logic [AMT_W:0] FULL = (AMT_W+1)'(DATA_W);

  logic              go_left;
  logic              fill;
  logic [DATA_W-1:0] src_rev;
  logic [DATA_W-1:0] out_rev;
  logic [DATA_W-1:0] stage [AMT_W+1];
  logic [AMT_W:0]    pick;

  assign go_left = (kind == SH_LSL);
  assign fill    = (kind == SH_ASR) ? src[DATA_W-1] : 1'b0;

  // Left shifts run through the right-shift stages on a mirrored word.
  for (genvar b = 0; b < DATA_W; b++) begin : g_mirror
    assign src_rev[b] = src[DATA_W-1-b];
    assign out_rev[b] = stage[AMT_W][DATA_W-1-b];
  end

  assign stage[0] = go_left ? src_rev : src;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [DATA_W-1:0] moved;
    always_comb begin
      if (kind == SH_ROR) begin
        moved = {stage[k][S-1:0], stage[k][DATA_W-1:S]};
      end else begin
        moved = {{S{fill}}, stage[k][DATA_W-1:S]};
      end
    end
    assign stage[k+1] = amt[k] ? moved : stage[k];
  end

  always_comb begin
    res = go_left ? out_rev : stage[AMT_W];
    if (go_left) begin
      pick = FULL - {1'b0, amt};
    end else begin
      pick = {1'b0, amt} - 1'b1;
    end
    carry_out = (amt == '0) ? carry_in : src[pick[AMT_W-1:0]];
  end

endmodule

// File: rtl/rot_operand_shifter.sv
module rot_operand_shifter
  import rot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 9,
  parameter int REG_W  = 5
) (
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] rm_val_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] operand_o,
  output logic              carry_o,
  output logic              op_valid_o,
  output logic              flags_upd_o,
  output logic              cmov_o,
  output logic [REG_W-1:0]  cmov_cond_o
);

  localparam int AMT_W = $clog2(DATA_W);

  logic              is_imm;
  logic              is_valid;
  logic              amt_from_reg;
  shift_kind_e       kind;
  logic [AMT_W-1:0]  amt_field;
  logic [IMM_W-1:0]  imm_field;
  logic [AMT_W-1:0]  reg_amt;
  logic [DATA_W-1:0] imm_res;
  logic              imm_carry;
  logic [DATA_W-1:0] sh_res;
  logic              sh_carry;
  logic [DATA_W-AMT_W-1:0] unused_rs_hi;

  assign unused_rs_hi = rs_val_i[DATA_W-1:AMT_W];

  rot_decode #(
    .IMM_W (IMM_W),
    .AMT_W (AMT_W),
    .REG_W (REG_W)
  ) u_decode (
    .instr        (instr_i),
    .is_imm       (is_imm),
    .is_valid     (is_valid),
    .amt_from_reg (amt_from_reg),
    .kind         (kind),
    .amt_field    (amt_field),
    .imm_field    (imm_field),
    .flags_upd    (flags_upd_o),
    .is_cmov      (cmov_o),
    .cond_field   (cmov_cond_o)
  );

  rot_imm_rotator #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .AMT_W  (AMT_W)
  ) u_imm (
    .imm       (imm_field),
    .amt       (amt_field),
    .carry_in  (carry_i),
    .res       (imm_res),
    .carry_out (imm_carry)
  );

  assign reg_amt = amt_from_reg ? rs_val_i[AMT_W-1:0] : amt_field;

  rot_barrel #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W)
  ) u_barrel (
    .src       (rm_val_i),
    .amt       (reg_amt),
    .kind      (kind),
    .carry_in  (carry_i),
    .res       (sh_res),
    .carry_out (sh_carry)
  );

  always_comb begin
    op_valid_o = is_valid;
    if (!is_valid) begin
      operand_o = '0;
      carry_o   = carry_i;
    end else if (is_imm) begin
      operand_o = imm_res;
      carry_o   = imm_carry;
    end else begin
      operand_o = sh_res;
      carry_o   = sh_carry;
    end
  end

endmodule

// File: rtl/rot_operand_shifter_chk.sv
module rot_operand_shifter_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input logic [31:0]       instr_i,
  input logic [DATA_W-1:0] rm_val_i,
  input logic [DATA_W-1:0] rs_val_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] operand_o,
  input logic              carry_o,
  input logic              op_valid_o,
  input logic              flags_upd_o,
  input logic              cmov_o,
  input logic [REG_W-1:0]  cmov_cond_o
);

  logic       imm_form;
  logic       reg_form;
  logic [4:0] eff_amt;

  always_comb begin
    imm_form = (instr_i[31:29] == 3'b001);
    reg_form = (instr_i[31:29] == 3'b000) && !instr_i[8];
    eff_amt  = instr_i[5] ? rs_val_i[4:0] : instr_i[13:9];

    p_valid_decode_r1: assert (op_valid_o == (imm_form || reg_form))
      else $error("valid decode mismatch");
    p_invalid_quiet_r1: assert (op_valid_o ||
        (operand_o == '0 && carry_o == carry_i && !cmov_o && !flags_upd_o))
      else $error("invalid instruction leaked outputs");
    p_imm_bits_kept_r2: assert (!imm_form ||
        $countones(operand_o) == $countones(instr_i[8:0]))
      else $error("immediate rotation changed bit count");
    p_imm_carry_r3: assert (!imm_form || instr_i[13:9] == 5'd0 ||
        carry_o == operand_o[DATA_W-1])
      else $error("immediate carry not result msb");
    p_lsl_low_zero_r5: assert (!reg_form || instr_i[7:6] != 2'b00 ||
        eff_amt == 5'd0 || !operand_o[0])
      else $error("left shift left a low bit set");
    p_ror_bits_kept_r5: assert (!reg_form || instr_i[7:6] != 2'b11 ||
        $countones(operand_o) == $countones(rm_val_i))
      else $error("rotate changed bit count");
    p_zero_amt_pass_r7: assert (!reg_form || eff_amt != 5'd0 ||
        (operand_o == rm_val_i && carry_o == carry_i))
      else $error("zero amount did not pass through");
    p_cmov_decode_r8: assert (!cmov_o || (op_valid_o &&
        (instr_i[28:25] == 4'b1101 || instr_i[28:25] == 4'b1111)))
      else $error("conditional move flagged wrongly");
    p_cmov_field_r8: assert (cmov_cond_o == instr_i[23:19])
      else $error("condition field mismatch");
    p_flags_r9: assert (flags_upd_o == (op_valid_o && instr_i[24]))
      else $error("flag update mismatch");
  end

endmodule

bind rot_operand_shifter rot_operand_shifter_chk #(
  .DATA_W (DATA_W),
  .REG_W  (REG_W)
) u_chk (
  .instr_i     (instr_i),
  .rm_val_i    (rm_val_i),
  .rs_val_i    (rs_val_i),
  .carry_i     (carry_i),
  .operand_o   (operand_o),
  .carry_o     (carry_o),
  .op_valid_o  (op_valid_o),
  .flags_upd_o (flags_upd_o),
  .cmov_o      (cmov_o),
  .cmov_cond_o (cmov_cond_o)
);

// File: tb/rot_operand_shifter_tb_top.sv
module rot_operand_shifter_tb_top;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [31:0] rm_val;
  logic [31:0] rs_val;
  logic        cin;
  logic [31:0] operand;
  logic        cout;
  logic        op_valid;
  logic        flags_upd;
  logic        cmov;
  logic [4:0]  cmov_cond;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;
  bit done     = 0;

  rot_operand_shifter dut_i (
    .instr_i     (instr),
    .rm_val_i    (rm_val),
    .rs_val_i    (rs_val),
    .carry_i     (cin),
    .operand_o   (operand),
    .carry_o     (cout),
    .op_valid_o  (op_valid),
    .flags_upd_o (flags_upd),
    .cmov_o      (cmov),
    .cmov_cond_o (cmov_cond)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000 && !done) begin
      n_errors = n_errors + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog: actual=%0d expected<5000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_errors = n_errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] m,
                       input logic [31:0] s, input logic c);
    @(posedge clk);
    instr  = i;
    rm_val = m;
    rs_val = s;
    cin    = c;
    @(negedge clk);
  endtask

  // fields: cls(3) opc(4) s(1) rn(5) f13_9(5) low9(9) rm(32) rs(32) cin(1) exp_op(32) exp_c(1)
  localparam int VW = 125;
  localparam int NV = 14;
  localparam logic [VW-1:0] VEC [NV] = '{
    // R2 R3: zero rotation keeps immediate, carry from input
    {3'b001, 4'h0, 1'b0, 5'd0, 5'd0,  9'h1FF, 32'h0, 32'h0, 1'b1, 32'h0000_01FF, 1'b1},
    // R2 R3: rotate 28 wraps, carry is msb
    {3'b001, 4'h0, 1'b0, 5'd0, 5'd28, 9'h1FF, 32'h0, 32'h0, 1'b0, 32'hF000_001F, 1'b1},
    // R2 R3: small rotation, msb 0
    {3'b001, 4'h0, 1'b0, 5'd0, 5'd4,  9'h001, 32'h0, 32'h0, 1'b1, 32'h0000_0010, 1'b0},
    // R5 R6: LSL 4
    {3'b000, 4'h0, 1'b0, 5'd0, 5'd4,  9'h000, 32'h1000_000F, 32'h0, 1'b0, 32'h0000_00F0, 1'b1},
    // R5 R6: LSR 8
    {3'b000, 4'h0, 1'b0, 5'd0, 5'd8,  9'h040, 32'h1234_5680, 32'h0, 1'b0, 32'h0012_3456, 1'b1},
    // R5 R6: ASR 4
    {3'b000, 4'h0, 1'b0, 5'd0, 5'd4,  9'h080, 32'h8000_0008, 32'h0, 1'b0, 32'hF800_0000, 1'b1},
    // R5 R6: ROR 8
    {3'b000, 4'h0, 1'b0, 5'd0, 5'd8,  9'h0C0, 32'h0000_00A5, 32'h0, 1'b0, 32'hA500_0000, 1'b1},
    // R4: amount from Rs low bits, upper bits ignored
    {3'b000, 4'h0, 1'b0, 5'd0, 5'd3,  9'h020, 32'h0000_000F, 32'hFFFF_FF04, 1'b1, 32'h0000_00F0, 1'b0},
    // R4 R7: Rs = 0x20 gives amount 0
    {3'b000, 4'h0, 1'b0, 5'd0, 5'd3,  9'h060, 32'hDEAD_BEEF, 32'h0000_0020, 1'b1, 32'hDEAD_BEEF, 1'b1},
    // R7: constant amount 0 under ASR
    {3'b000, 4'h0, 1'b0, 5'd0, 5'd0,  9'h080, 32'h8000_0001, 32'h0, 1'b0, 32'h8000_0001, 1'b0},
    // R1: class 010 is not an operand form
    {3'b010, 4'h0, 1'b0, 5'd0, 5'd4,  9'h000, 32'hFFFF_FFFF, 32'h0, 1'b1, 32'h0000_0000, 1'b1},
    // R1: class 000 with bit 8 set
    {3'b000, 4'h0, 1'b0, 5'd0, 5'd4,  9'h190, 32'hFFFF_FFFF, 32'h0, 1'b0, 32'h0000_0000, 1'b0},
    // R5 R6: ASR 31
    {3'b000, 4'h0, 1'b0, 5'd0, 5'd31, 9'h080, 32'h4000_0000, 32'h0, 1'b0, 32'h0000_0000, 1'b1},
    // R5 R6: LSL 31
    {3'b000, 4'h0, 1'b0, 5'd0, 5'd31, 9'h000, 32'h0000_0003, 32'h0, 1'b0, 32'h8000_0000, 1'b1}
  };

  function automatic logic [31:0] mk(input logic [2:0] cls, input logic [3:0] opc,
                                     input logic s, input logic [4:0] rn,
                                     input logic [4:0] f13, input logic [8:0] low9);
    return {cls, opc, s, rn, 5'd7, f13, low9};
  endfunction

  initial begin
    instr  = '0;
    rm_val = '0;
    rs_val = '0;
    cin    = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(posedge clk);
    rst_n  = 1'b1;

    // Idle inputs: all-zero word is LSL #0 of zero (R7, R1)
    apply(32'h0, 32'h0, 32'h0, 1'b1);
    check("R7 idle operand", operand, 32'h0);
    check("R7 idle carry", 32'(cout), 32'h1);
    check("R1 idle valid", 32'(op_valid), 32'h1);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      string tag;
      v = VEC[i];
      apply(mk(v[124:122], v[121:118], v[117], v[116:112], v[111:107], v[106:98]),
            v[97:66], v[65:34], v[33]);
      tag = $sformatf("R2-R7 vec%0d operand", i);
      check(tag, operand, v[32:1]);
      tag = $sformatf("R3/R6 vec%0d carry", i);
      check(tag, 32'(cout), 32'(v[0]));
    end

    // R8: move opcode, register form
    apply(mk(3'b000, 4'b1101, 1'b0, 5'h0B, 5'd0, 9'h000), 32'h5, 32'h0, 1'b0);
    check("R8 mov cmov", 32'(cmov), 32'h1);
    check("R8 mov cond", 32'(cmov_cond), 32'h0B);
    check("R7 mov operand", operand, 32'h5);
    // R8: move inverted, immediate form
    apply(mk(3'b001, 4'b1111, 1'b1, 5'h03, 5'd0, 9'h0AA), 32'h0, 32'h0, 1'b0);
    check("R8 mvn cmov", 32'(cmov), 32'h1);
    check("R8 mvn cond", 32'(cmov_cond), 32'h03);
    check("R9 flags set", 32'(flags_upd), 32'h1);
    // R8: other opcode is not a conditional move
    apply(mk(3'b000, 4'b0100, 1'b0, 5'h03, 5'd0, 9'h000), 32'h0, 32'h0, 1'b0);
    check("R8 add no cmov", 32'(cmov), 32'h0);
    check("R9 flags clear", 32'(flags_upd), 32'h0);
    // R1 R8 R9: move opcode in an invalid class
    apply(mk(3'b011, 4'b1101, 1'b1, 5'h03, 5'd0, 9'h000), 32'h0, 32'h0, 1'b1);
    check("R1 invalid cmov", 32'(cmov), 32'h0);
    check("R9 invalid flags", 32'(flags_upd), 32'h0);
    check("R1 invalid valid", 32'(op_valid), 32'h0);
    check("R1 invalid carry", 32'(cout), 32'h1);
    // R5 R6: ROR by 1 through Rs, carry from bit 0
    apply(mk(3'b000, 4'h0, 1'b0, 5'd0, 5'd2, 9'h0E0), 32'h0000_0001, 32'h0000_0001, 1'b0);
    check("R5 ror1 operand", operand, 32'h8000_0000);
    check("R6 ror1 carry", 32'(cout), 32'h1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule